// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block is the architectural register store of a 32-bit processor core. It presents sixteen general registers (index 0 to 15) through two combinational read ports and one clocked write port. It also keeps the shadow copies that are exchanged with the live registers when the core changes privilege mode. Each exceptional mode owns its own stack pointer (index 13), link register (index 14) and saved status word. The fast-interrupt mode also owns private copies of registers 8 to 12.

A mode change is requested by raising `mode_req` with a 5-bit target code. At the next clock edge the block does three things together: it parks the outgoing mode's banked values, loads the incoming mode's values into the live registers, and records the new mode. A register write or saved-status write in the same cycle lands in the incoming mode's view. Instruction decode, arithmetic and exception vectoring live elsewhere. Reset clears every register and every shadow copy, and the core starts in system mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset all sixteen registers read zero, `cur_mode` is 0x1F (system), `saved_status` is zero, and every shadow copy of every mode also reads zero once that mode is entered.
- R2: `rd_a_data` and `rd_b_data` show the live register selected by `rd_a_idx` and `rd_b_idx` in the same cycle, with no clock edge in between.
- R3: With `wr_en` high, register `wr_idx` takes `wr_data` at the clock edge, and from the next cycle it is visible on both read ports.
- R4: Mode codes map to banks as follows: 0x10 user and 0x1F system share one unbanked set. 0x11 fast-interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort and 0x1B undefined each own a bank. Every other code maps to the unbanked set.
- R5: When a mode change moves between two different banks, indices 13 and 14 and the saved status are stored to the old bank, and the new bank's copies become live at the same clock edge.
- R6: Indices 8 to 12 are exchanged only when the old mode or the new mode is fast-interrupt. They switch between the fast-interrupt copy and a single copy shared by all other modes.
- R7: A mode request whose target equals `cur_mode` leaves every register, the saved status and the mode unchanged.
- R8: A change between two modes that map to the same bank exchanges no register, but `cur_mode` takes the new code.
- R9: With `psr_wr_en` high, the saved status of the current bank takes `psr_wr_data`. Each bank keeps its own value across later mode changes.
- R10: A register or saved-status write in the same cycle as a mode change updates the new mode's view. The old mode's parked copy is not changed.
- R11: Indices 0 to 7 and 15 are never changed by a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| mode_req | input | 1 | Mode change request |
| mode_tgt | input | 5 | Target mode code |
| psr_wr_en | input | 1 | Saved status write enable |
| psr_wr_data | input | 32 | Saved status write data |
| cur_mode | output | 5 | Mode now in effect |
| saved_status | output | 32 | Saved status of the current bank |

## Verification
The bench holds a logical model of every bank and compares all sixteen registers, the mode and the saved status after every edge. It uses directed steps first and then several thousand random steps. It targets the following cases:
- Interrupt-to-fast-interrupt moves. A design that parked registers 8 to 12 only when leaving fast-interrupt would lose the shared copy.
- User-to-system moves and unknown mode codes. A design that swapped here would scramble the stack pointer, and one that ignored the move would leave a stale mode code.
- Writes in the same cycle as a mode change. Writing the old view would corrupt the parked copy and miss the live register.
- Repeated requests for the mode already in effect. These must change nothing.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;

    localparam int NUM_REGS = 16;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int MODE_W   = 5;
    localparam int NUM_BANK = 6;
    localparam int BANK_W   = $clog2(NUM_BANK);
    localparam int HI_BASE  = 8;
    localparam int HI_CNT   = 5;
    localparam int SP_IDX   = 13;
    localparam int LR_IDX   = 14;

    localparam logic [MODE_W-1:0] MD_USR = 5'h10;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

    typedef enum logic [BANK_W-1:0] {
        BK_NONE = 3'd0,
        BK_FIQ  = 3'd1,
        BK_IRQ  = 3'd2,
        BK_SVC  = 3'd3,
        BK_ABT  = 3'd4,
        BK_UND  = 3'd5
    } bank_e;

    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bankreg_decode.sv
`timescale 1ns/1ps
module bankreg_decode
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [BANK_W-1:0] bank,
    output logic              is_fiq
);
    bank_e sel;

    always_comb begin
        sel    = mode_to_bank(mode);
        bank   = sel;
        is_fiq = (sel == BK_FIQ);
    end
endmodule

// File: rtl/bankreg_rdport.sv
`timescale 1ns/1ps
module bankreg_rdport
    import bankreg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [NUM_REGS-1:0][DW-1:0] regs,
    input  logic [IDX_W-1:0]            idx,
    output logic [DW-1:0]               data
);
    always_comb begin
        data = regs[idx];
    end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPORT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_req,
    input  logic [4:0]        mode_tgt,
    input  logic              psr_wr_en,
    input  logic [DATA_W-1:0] psr_wr_data,
    output logic [4:0]        cur_mode,
    output logic [DATA_W-1:0] saved_status
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0]          gpr;
        logic [NUM_BANK-1:0][DATA_W-1:0]          sp_bank;
        logic [NUM_BANK-1:0][DATA_W-1:0]          lr_bank;
        logic [NUM_BANK-1:0][DATA_W-1:0]          psr_bank;
        logic [1:0][HI_CNT-1:0][DATA_W-1:0]       hi_bank;
        logic [DATA_W-1:0]                        psr;
        logic [MODE_W-1:0]                        mode;
    } state_t;

    state_t st_d, st_q;

    logic [BANK_W-1:0] old_bank, new_bank;
    logic              old_fiq, new_fiq;

    bankreg_decode u_dec_old (
        .mode   (st_q.mode),
        .bank   (old_bank),
        .is_fiq (old_fiq)
    );

    bankreg_decode u_dec_new (
        .mode   (mode_tgt),
        .bank   (new_bank),
        .is_fiq (new_fiq)
    );

    // next-state logic: swap first, then writes land in the new view
    always_comb begin
        st_d = st_q;
        if (mode_req && (mode_tgt != st_q.mode)) begin
            if (old_bank != new_bank) begin
                st_d.sp_bank[old_bank]  = st_q.gpr[SP_IDX];
                st_d.lr_bank[old_bank]  = st_q.gpr[LR_IDX];
                st_d.psr_bank[old_bank] = st_q.psr;
                st_d.gpr[SP_IDX]        = st_q.sp_bank[new_bank];
                st_d.gpr[LR_IDX]        = st_q.lr_bank[new_bank];
                st_d.psr                = st_q.psr_bank[new_bank];
                if (old_fiq || new_fiq) begin
                    for (int k = 0; k < HI_CNT; k++) begin
                        st_d.hi_bank[old_fiq][k] = st_q.gpr[HI_BASE+k];
                        st_d.gpr[HI_BASE+k]      = st_q.hi_bank[new_fiq][k];
                    end
                end
            end
            st_d.mode = mode_tgt;
        end
        if (wr_en) begin
            st_d.gpr[wr_idx] = wr_data;
        end
        if (psr_wr_en) begin
            st_d.psr = psr_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_SYS;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NPORT-1:0][IDX_W-1:0]  rd_idx;
    logic [NPORT-1:0][DATA_W-1:0] rd_data;

    always_comb begin
        rd_idx[0] = rd_a_idx;
        rd_idx[1] = rd_b_idx;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        bankreg_rdport #(.DW(DATA_W)) u_rd (
            .regs (st_q.gpr),
            .idx  (rd_idx[p]),
            .data (rd_data[p])
        );
    end

    assign rd_a_data    = rd_data[0];
    assign rd_b_data    = rd_data[1];
    assign cur_mode     = st_q.mode;
    assign saved_status = st_q.psr;

endmodule

// File: rtl/bankreg_chk.sv
`timescale 1ns/1ps
module bankreg_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    rd_a_idx,
    input logic [DW-1:0] rd_a_data,
    input logic [3:0]    rd_b_idx,
    input logic [DW-1:0] rd_b_data,
    input logic          wr_en,
    input logic [3:0]    wr_idx,
    input logic [DW-1:0] wr_data,
    input logic          mode_req,
    input logic [4:0]    mode_tgt,
    input logic          psr_wr_en,
    input logic [DW-1:0] psr_wr_data,
    input logic [4:0]    cur_mode,
    input logic [DW-1:0] saved_status
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_mode == 5'h1F && saved_status == '0));

    // R3
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 (rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

    // R7
    same_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && mode_tgt == cur_mode && !psr_wr_en)
        |=> ($stable(saved_status) && $stable(cur_mode)));

    // R8
    mode_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req |=> cur_mode == $past(mode_tgt));

    // R9
    psr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_wr_en |=> saved_status == $past(psr_wr_data));

    // R11
    low_regs_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && !wr_en) ##1
        (rd_b_idx == $past(rd_b_idx) && (rd_b_idx < 4'd8 || rd_b_idx == 4'd15))
        |-> $stable(rd_b_data));
endmodule

bind banked_regfile bankreg_chk #(.DW(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .rd_b_idx     (rd_b_idx),
    .rd_b_data    (rd_b_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .mode_req     (mode_req),
    .mode_tgt     (mode_tgt),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .cur_mode     (cur_mode),
    .saved_status (saved_status)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/100ps
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0, saved_status;
    logic        wr_en = 1'b0, mode_req = 1'b0, psr_wr_en = 1'b0;
    logic [4:0]  mode_tgt = '0, cur_mode;

    always #4 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .mode_req(mode_req), .mode_tgt(mode_tgt),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .cur_mode(cur_mode), .saved_status(saved_status)
    );

    int n_chk = 0;
    int n_err = 0;

    // logical model: one copy per bank, no swapping
    logic [31:0] m_low [16];
    logic [31:0] m_hi  [2][5];
    logic [31:0] m_sp  [6];
    logic [31:0] m_lr  [6];
    logic [31:0] m_psr [6];
    logic [4:0]  m_mode;

    function automatic int bk(input logic [4:0] m);
        case (m)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] exp_reg(input int i);
        int b;
        b = bk(m_mode);
        if (i >= 8 && i <= 12) return m_hi[(b == 1) ? 1 : 0][i-8];
        if (i == 13) return m_sp[b];
        if (i == 14) return m_lr[b];
        return m_low[i];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic verify_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i);
            rd_b_idx = 4'(15 - i);
            #0.1;
            chk({tag, " R2 port A"}, rd_a_data, exp_reg(i));
            chk({tag, " R2 port B"}, rd_b_data, exp_reg(15 - i));
        end
        chk({tag, " mode"}, {27'd0, cur_mode}, {27'd0, m_mode});
        chk({tag, " R9 saved status"}, saved_status, m_psr[bk(m_mode)]);
    endtask

    task automatic step(input string tag, input logic req, input logic [4:0] tgt,
                        input logic we, input logic [3:0] wi, input logic [31:0] wd,
                        input logic pwe, input logic [31:0] pd);
        int b, hi;
        @(negedge clk);
        mode_req = req; mode_tgt = tgt;
        wr_en = we; wr_idx = wi; wr_data = wd;
        psr_wr_en = pwe; psr_wr_data = pd;
        @(posedge clk);
        if (req) m_mode = tgt;
        b  = bk(m_mode);
        hi = (b == 1) ? 1 : 0;
        if (we) begin
            if (wi >= 8 && wi <= 12) m_hi[hi][wi-8] = wd;
            else if (wi == 13) m_sp[b] = wd;
            else if (wi == 14) m_lr[b] = wd;
            else m_low[wi] = wd;
        end
        if (pwe) m_psr[b] = pd;
        #1;
        verify_all(tag);
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [4:0] tg;
        for (int i = 0; i < 16; i++) m_low[i] = '0;
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_psr[i] = '0; end
        for (int i = 0; i < 5; i++) begin m_hi[0][i] = '0; m_hi[1][i] = '0; end
        m_mode = 5'h1F;
        void'($urandom(32'h1D5E));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        verify_all("R1 reset");

        // R3: fill every register in system mode
        for (int i = 0; i < 16; i++)
            step("R3 write", 1'b0, 5'h0, 1'b1, 4'(i), 32'h100 + 32'(i), 1'b0, '0);
        step("R9 psr write", 1'b0, 5'h0, 1'b0, 4'd0, '0, 1'b1, 32'h0000_00F0);
        // R6 entering fast-interrupt: its r8-r14 copies are zero (R1)
        step("R6 R1 enter fiq", 1'b1, 5'h11, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R6 fiq write", 1'b0, 5'h0, 1'b1, 4'd8, 32'hAAAA_0008, 1'b1, 32'h55);
        step("R5 fiq sp write", 1'b0, 5'h0, 1'b1, 4'd13, 32'hFFFF_0013, 1'b0, '0);
        // R10: write lr in the same cycle as move to interrupt mode
        step("R10 R6 fiq to irq", 1'b1, 5'h12, 1'b1, 4'd14, 32'h1234_0014, 1'b1, 32'h77);
        step("R7 same mode", 1'b1, 5'h12, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R5 irq to user", 1'b1, 5'h10, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R8 user to system", 1'b1, 5'h1F, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R4 unknown code", 1'b1, 5'h05, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R4 R11 to svc", 1'b1, 5'h13, 1'b1, 4'd13, 32'h5C5C_0013, 1'b0, '0);
        step("R4 to und", 1'b1, 5'h1B, 1'b0, 4'd0, '0, 1'b1, 32'h1B);
        step("R4 to abt", 1'b1, 5'h17, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R6 back to fiq", 1'b1, 5'h11, 1'b0, 4'd0, '0, 1'b0, '0);
        step("R7 same fiq", 1'b1, 5'h11, 1'b1, 4'd9, 32'h9999, 1'b0, '0);
        step("R6 fiq to svc", 1'b1, 5'h13, 1'b0, 4'd0, '0, 1'b0, '0);

        for (int n = 0; n < 3000; n++) begin
            case ($urandom % 9)
                0: tg = 5'h10;
                1: tg = 5'h11;
                2: tg = 5'h12;
                3: tg = 5'h13;
                4: tg = 5'h17;
                5: tg = 5'h1B;
                6: tg = 5'h1F;
                7: tg = 5'($urandom);
                default: tg = m_mode;
            endcase
            step("R5 R6 R10 random", ($urandom % 5) < 2, tg,
                 ($urandom % 5) < 3, 4'($urandom), $urandom,
                 ($urandom % 5) == 0, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule